// File: doc/BRIEF.md
# SMBus Status Byte Read Responder

This block is a target on a two-wire SMBus segment. An external master reads one byte at a time from a small bank of on-chip status sources. The block watches the clock and data lines and pulls data low through an open-drain enable. It compares the 7-bit address in each address phase with a programmable receive address. It latches the command byte and, after a repeated start, shifts out the byte that the command selects.

The bank holds several sources: a status byte with a core-power-failure flag and a mirrored thermal-trip flag, two message bytes, a watchdog count, and seven calendar/time bytes. The time bytes are copied into a snapshot only while the bus is idle and the time source is not updating. This keeps them coherent while a read is in progress on the wire. The block assumes the master follows the byte-read protocol, so it does not check the direction bit in either address phase.

Top module: `smb_rd_slave`

## Requirements
- R1: After reset the block does not drive SDA (`sda_oe_o` = 0). It stays released in idle until a start condition is seen.
- R2: The first address phase takes 7 address bits, MSB first, and compares them with `own_addr_i`. On a match the block pulls SDA low for the 9th clock. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R3: The direction bit (8th bit) of the first address phase is ignored. A matching address with the read bit set is still acknowledged and served.
- R4: After a matching first address, the 8-bit command byte is received MSB first and acknowledged.
- R5: A repeated start after the command opens a second address phase. On a match its direction bit is ignored, the address is acknowledged, and the selected byte is driven MSB first, one bit per clock.
- R6: The command value selects the byte as follows:
  - 05h is the status byte: bit0 = power failure (`sleep_s3_n_i` high while `pwr_good_i` low), bit1 = `therm_trip_i`, bits 7:2 = 0.
  - 06h returns `msg1_i`, 07h returns `msg2_i`, and 08h returns `wdog_cnt_i`.
  - 09h to 0Fh return the snapshot time bytes in this order: seconds, minutes, hours, day of week, day of month, month, year (`rtc_i` byte 0 to byte 6).
- R7: Command values 00h to 04h and 10h to FFh return 00h.
- R8: SDA is released for the master's acknowledge slot after the data byte. The block stays released until a stop, even if the master acknowledges and keeps clocking.
- R9: A stop condition at any point returns the block to idle with SDA released. A later start begins a fresh transaction.
- R10: The time snapshot follows `rtc_i` on every clock while the bus is idle and `rtc_upd_i` is low. It holds its value during a transaction and while `rtc_upd_i` is high.
- R11: `sda_oe_o` changes only while SCL is low.
- R12: Changes on the status inputs (thermal trip, power-good, sleep) cause no bus activity on their own. SDA stays released while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open drain) |
| own_addr_i | input | 7 | Programmable receive address |
| sleep_s3_n_i | input | 1 | Sleep-S3 request, active low |
| pwr_good_i | input | 1 | Core power good |
| therm_trip_i | input | 1 | Thermal-trip status |
| msg1_i | input | 8 | Message byte 1 |
| msg2_i | input | 8 | Message byte 2 |
| wdog_cnt_i | input | 8 | Watchdog count value |
| rtc_upd_i | input | 1 | Time bytes are changing; freeze snapshot |
| rtc_i | input | 56 | Time bytes, byte 0 = seconds to byte 6 = year |

## Verification
Some rules are checked by assertions on every cycle:
- the snapshot hold and track rules;
- SDA released whenever the engine is idle or done with the byte;
- the open-drain enable changing only with SCL low;
- any stop forcing idle on the next cycle;
- the bit counter staying inside a byte.

Other behaviour can only be shown by the bench scenarios that drive the wire:
- the acknowledge decisions for matching and mismatching addresses with either direction bit;
- the index-to-byte mapping including unassigned values;
- aborts by stop mid-address and while waiting for the repeated start;
- a master that acknowledges and keeps clocking;
- a time change landing in the middle of a read.

// File: rtl/smb_rd_pkg.sv
package smb_rd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W) + 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ACK1,
    ST_CMD,
    ST_ACK2,
    ST_WAIT_RS,
    ST_ADDR2,
    ST_ACK3,
    ST_DATA,
    ST_MACK,
    ST_DONE
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // data edges while clock stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_rd_pkg::*;
#(
  parameter int unsigned RTC_BYTES  = 7,
  parameter int unsigned RTC_BASE   = 9,
  parameter int unsigned STATUS_IDX = 5,
  parameter int unsigned MSG1_IDX   = 6,
  parameter int unsigned MSG2_IDX   = 7,
  parameter int unsigned WDOG_IDX   = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          idle_i,
  input  logic                          rtc_upd_i,
  input  logic [RTC_BYTES*BYTE_W-1:0]   rtc_i,
  input  logic                          sleep_s3_n_i,
  input  logic                          pwr_good_i,
  input  logic                          therm_trip_i,
  input  logic [BYTE_W-1:0]             msg1_i,
  input  logic [BYTE_W-1:0]             msg2_i,
  input  logic [BYTE_W-1:0]             wdog_cnt_i,
  input  logic [BYTE_W-1:0]             idx_i,
  output logic [BYTE_W-1:0]             rd_data_o
);
  logic [BYTE_W-1:0] rtc_q [RTC_BYTES];
  logic [BYTE_W-1:0] status_byte;
  logic              capture;

  assign capture = idle_i & ~rtc_upd_i;

  for (genvar k = 0; k < RTC_BYTES; k++) begin : g_rtc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rtc_q[k] <= '0;
      else if (capture) rtc_q[k] <= rtc_i[k*BYTE_W +: BYTE_W];
    end

    assert_rtc_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!idle_i || rtc_upd_i) |=> $stable(rtc_q[k]));
    assert_rtc_track_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idle_i && !rtc_upd_i) |=> rtc_q[k] == $past(rtc_i[k*BYTE_W +: BYTE_W]));
  end

  // core power failure: S3 exit requested but power not good
  assign status_byte = {{(BYTE_W-2){1'b0}}, therm_trip_i, sleep_s3_n_i & ~pwr_good_i};

  always_comb begin
    rd_data_o = '0;
    if (idx_i == BYTE_W'(STATUS_IDX)) rd_data_o = status_byte;
    if (idx_i == BYTE_W'(MSG1_IDX))   rd_data_o = msg1_i;
    if (idx_i == BYTE_W'(MSG2_IDX))   rd_data_o = msg2_i;
    if (idx_i == BYTE_W'(WDOG_IDX))   rd_data_o = wdog_cnt_i;
    for (int k = 0; k < RTC_BYTES; k++) begin
      if (idx_i == BYTE_W'(RTC_BASE + k)) rd_data_o = rtc_q[k];
    end
  end
endmodule

// File: rtl/smb_rd_fsm.sv
module smb_rd_fsm
  import smb_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [BYTE_W-1:0] idx_o,
  output logic              idle_o,
  output logic              sda_oe_o
);
  smb_state_e        state;
  logic [ADDR_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] cmd_q;
  logic              oe_q;
  logic [BYTE_W-1:0] rx;
  logic              last_bit;
  logic              hit;

  assign rx       = {shreg, sda_s_i};
  assign last_bit = (cnt == CNT_W'(BYTE_W - 1));
  assign hit      = (shreg == own_addr_i);  // direction bit not compared

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      shreg <= '0;
      cnt   <= '0;
      tx    <= '0;
      cmd_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_i) begin
      state <= ST_IDLE;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (start_i) begin
      state <= (state == ST_WAIT_RS) ? ST_ADDR2 : ST_ADDR1;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else if (scl_rise_i) begin
      unique case (state)
        ST_ADDR1, ST_CMD, ST_ADDR2: begin
          shreg <= rx[ADDR_W-1:0];
          cnt   <= last_bit ? '0 : cnt + 1'b1;
          if (last_bit) begin
            unique case (state)
              ST_ADDR1: state <= hit ? ST_ACK1 : ST_IDLE;
              ST_ADDR2: state <= hit ? ST_ACK3 : ST_IDLE;
              default: begin
                cmd_q <= rx;
                state <= ST_ACK2;
              end
            endcase
          end
        end
        ST_ACK1: state <= ST_CMD;
        ST_ACK2: state <= ST_WAIT_RS;
        ST_ACK3: begin
          state <= ST_DATA;
          tx    <= rd_data_i;
        end
        ST_DATA: begin
          tx  <= {tx[BYTE_W-2:0], 1'b0};
          cnt <= last_bit ? '0 : cnt + 1'b1;
          if (last_bit) state <= ST_MACK;
        end
        ST_MACK: state <= ST_DONE;
        default: ;
      endcase
    end else if (scl_fall_i) begin
      unique case (state)
        ST_ACK1, ST_ACK2, ST_ACK3: oe_q <= 1'b1;
        ST_DATA:                   oe_q <= ~tx[BYTE_W-1];
        default:                   oe_q <= 1'b0;
      endcase
    end
  end

  assign idx_o    = cmd_q;
  assign idle_o   = (state == ST_IDLE);
  assign sda_oe_o = oe_q;

  assert_idle_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !oe_q);
  assert_cnt_in_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CNT_W'(BYTE_W));
  assert_done_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> (state != ST_DONE && state != ST_ADDR1 && state != ST_ADDR2));
  assert_stop_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state == ST_IDLE && !oe_q));
  assert_sda_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_s_i);
endmodule

// File: rtl/smb_rd_slave.sv
module smb_rd_slave
  import smb_rd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RTC_BYTES   = 7,
  parameter int unsigned RTC_BASE    = 9,
  parameter int unsigned STATUS_IDX  = 5,
  parameter int unsigned MSG1_IDX    = 6,
  parameter int unsigned MSG2_IDX    = 7,
  parameter int unsigned WDOG_IDX    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe_o,
  input  logic [ADDR_W-1:0]           own_addr_i,
  input  logic                        sleep_s3_n_i,
  input  logic                        pwr_good_i,
  input  logic                        therm_trip_i,
  input  logic [BYTE_W-1:0]           msg1_i,
  input  logic [BYTE_W-1:0]           msg2_i,
  input  logic [BYTE_W-1:0]           wdog_cnt_i,
  input  logic                        rtc_upd_i,
  input  logic [RTC_BYTES*BYTE_W-1:0] rtc_i
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic idle;
  logic [BYTE_W-1:0] idx, rd_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  smb_rd_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .own_addr_i (own_addr_i),
    .rd_data_i  (rd_data),
    .idx_o      (idx),
    .idle_o     (idle),
    .sda_oe_o   (sda_oe_o)
  );

  smb_reg_bank #(
    .RTC_BYTES  (RTC_BYTES),
    .RTC_BASE   (RTC_BASE),
    .STATUS_IDX (STATUS_IDX),
    .MSG1_IDX   (MSG1_IDX),
    .MSG2_IDX   (MSG2_IDX),
    .WDOG_IDX   (WDOG_IDX)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idle_i       (idle),
    .rtc_upd_i    (rtc_upd_i),
    .rtc_i        (rtc_i),
    .sleep_s3_n_i (sleep_s3_n_i),
    .pwr_good_i   (pwr_good_i),
    .therm_trip_i (therm_trip_i),
    .msg1_i       (msg1_i),
    .msg2_i       (msg2_i),
    .wdog_cnt_i   (wdog_cnt_i),
    .idx_i        (idx),
    .rd_data_o    (rd_data)
  );
endmodule

// File: tb/smb_rd_slave_test.sv
`timescale 1ns/1ps
module smb_rd_slave_test;
  localparam int Q = 8;
  localparam logic [6:0] OWN = 7'h44;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  logic sleep_n = 1'b0, pg = 1'b1, therm = 1'b0, rtc_upd = 1'b0;
  logic [7:0] msg1 = 8'h00, msg2 = 8'h00, wd = 8'h00;
  logic [7:0] rtc_b [7];
  logic [55:0] rtc_flat;
  int tests = 0, fails = 0, viol = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  always_comb for (int k = 0; k < 7; k++) rtc_flat[k*8 +: 8] = rtc_b[k];

  smb_rd_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .own_addr_i(OWN), .sleep_s3_n_i(sleep_n), .pwr_good_i(pg), .therm_trip_i(therm),
    .msg1_i(msg1), .msg2_i(msg2), .wdog_cnt_i(wd), .rtc_upd_i(rtc_upd), .rtc_i(rtc_flat)
  );

  // R11 monitor: enable must not move while the master holds SCL high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] c);
    if (c == 8'h05) return {6'b0, therm, sleep_n & ~pg};
    if (c == 8'h06) return msg1;
    if (c == 8'h07) return msg2;
    if (c == 8'h08) return wd;
    if (c >= 8'h09 && c <= 8'h0F) return rtc_b[c - 8'h09];
    return 8'h00;
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic xfer_bit(input logic b, output logic r);
    sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_r);
    logic r;
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], r);
    xfer_bit(1'b1, ack_r);
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin xfer_bit(1'b1, r); d = {d[6:0], r}; end
  endtask

  task automatic rd_txn(input logic [6:0] a1, input logic d1, input logic [7:0] cmd,
                        input logic [6:0] a2, input logic d2, input logic mack,
                        input logic extra, output logic ack1, output logic ack2,
                        output logic ack3, output logic [7:0] data,
                        output logic [7:0] xdata, output logic quiet);
    logic r;
    ack1 = 0; ack2 = 0; ack3 = 0; data = '0; xdata = '0; quiet = 1;
    bus_start();
    send_byte({a1, d1}, r); ack1 = ~r;
    if (!ack1) begin bus_stop(); return; end
    send_byte(cmd, r); ack2 = ~r;
    bus_start();
    send_byte({a2, d2}, r); ack3 = ~r;
    if (!ack3) begin bus_stop(); return; end
    recv_byte(data);
    xfer_bit(mack, r);
    if (r !== mack) quiet = 0;
    if (extra) recv_byte(xdata);
    if (sda_oe) quiet = 0;
    bus_stop();
  endtask

  task automatic simple_read(input logic [7:0] cmd, output logic [7:0] d);
    logic a1, a2, a3, q; logic [7:0] x;
    rd_txn(OWN, 1'b0, cmd, OWN, 1'b1, 1'b1, 1'b0, a1, a2, a3, d, x, q);
  endtask

  task automatic randomize_inputs();
    msg1 = 8'($urandom); msg2 = 8'($urandom); wd = 8'($urandom);
    sleep_n = 1'($urandom); pg = 1'($urandom); therm = 1'($urandom);
    for (int k = 0; k < 7; k++) rtc_b[k] = 8'($urandom);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic a1, a2, a3, q, r;
    logic [7:0] d, x, old;
    int idle_drive;
    void'($urandom(32'd2024));
    for (int k = 0; k < 7; k++) rtc_b[k] = 8'h10 + 8'(k);
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset release", {7'b0, sda_oe}, 8'h00);

    // R12: status input activity alone never drives the bus
    idle_drive = 0;
    for (int i = 0; i < 40; i++) begin
      therm = ~therm; pg = i[1]; sleep_n = i[2];
      @(negedge clk);
      if (sda_oe) idle_drive++;
    end
    chk("R12 idle quiet on status change", 8'(idle_drive), 8'h00);

    // R6 map with fixed values
    msg1 = 8'hA5; msg2 = 8'h3C; wd = 8'h7E; sleep_n = 1'b1; pg = 1'b0; therm = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 5; c < 16; c++) begin
      simple_read(8'(c), d);
      chk($sformatf("R6 index %0h", c), d, exp_byte(8'(c)));
    end
    sleep_n = 1'b1; pg = 1'b1; therm = 1'b0;
    simple_read(8'h05, d);
    chk("R6 status no failure", d, 8'h00);
    sleep_n = 1'b0; pg = 1'b0;
    simple_read(8'h05, d);
    chk("R6 status in S3", d, 8'h00);

    // R7 unassigned indexes
    simple_read(8'h00, d); chk("R7 index 00", d, 8'h00);
    simple_read(8'h04, d); chk("R7 index 04", d, 8'h00);
    simple_read(8'h10, d); chk("R7 index 10", d, 8'h00);
    simple_read(8'hFF, d); chk("R7 index FF", d, 8'h00);

    // R3: read bit in first phase still claimed; R4 command ack
    rd_txn(OWN, 1'b1, 8'h06, OWN, 1'b1, 1'b1, 1'b0, a1, a2, a3, d, x, q);
    chk("R3 ack with read bit", {7'b0, a1}, 8'h01);
    chk("R4 command ack", {7'b0, a2}, 8'h01);
    chk("R3 data", d, msg1);

    // R5: write bit in second phase still served
    rd_txn(OWN, 1'b0, 8'h07, OWN, 1'b0, 1'b1, 1'b0, a1, a2, a3, d, x, q);
    chk("R5 second ack with write bit", {7'b0, a3}, 8'h01);
    chk("R5 data", d, msg2);

    // R2 mismatches
    rd_txn(OWN ^ 7'h01, 1'b0, 8'h06, OWN, 1'b1, 1'b1, 1'b0, a1, a2, a3, d, x, q);
    chk("R2 first mismatch no ack", {7'b0, a1}, 8'h00);
    rd_txn(OWN, 1'b0, 8'h06, OWN ^ 7'h40, 1'b1, 1'b1, 1'b0, a1, a2, a3, d, x, q);
    chk("R2 second mismatch no ack", {7'b0, a3}, 8'h00);
    chk("R2 line released", {7'b0, sda_oe}, 8'h00);

    // R8: master acks and keeps clocking; block stays off the line
    rd_txn(OWN, 1'b0, 8'h08, OWN, 1'b1, 1'b0, 1'b1, a1, a2, a3, d, x, q);
    chk("R8 data", d, wd);
    chk("R8 extra byte all ones", x, 8'hFF);
    chk("R8 released before stop", {7'b0, q}, 8'h01);
    rd_txn(OWN, 1'b0, 8'h07, OWN, 1'b1, 1'b1, 1'b0, a1, a2, a3, d, x, q);
    chk("R8 nack slot released", {7'b0, q}, 8'h01);

    // R9: stop mid-address, then stop while waiting for the repeated start
    bus_start();
    for (int i = 0; i < 4; i++) xfer_bit(OWN[6-i], r);
    bus_stop();
    chk("R9 abort in address", {7'b0, sda_oe}, 8'h00);
    simple_read(8'h06, d); chk("R9 read after abort", d, msg1);
    bus_start(); send_byte({OWN, 1'b0}, r); send_byte(8'h09, r); bus_stop();
    chk("R9 abort before repeated start", {7'b0, sda_oe}, 8'h00);
    simple_read(8'h09, d); chk("R9 read after second abort", d, rtc_b[0]);

    // R10: time change in mid transaction is not seen
    old = rtc_b[0];
    fork
      rd_txn(OWN, 1'b0, 8'h09, OWN, 1'b1, 1'b1, 1'b0, a1, a2, a3, d, x, q);
      begin repeat (450) @(negedge clk); rtc_b[0] = old ^ 8'hFF; end
    join
    chk("R10 held during read", d, old);
    simple_read(8'h09, d); chk("R10 tracks when idle", d, old ^ 8'hFF);
    rtc_upd = 1'b1; old = rtc_b[1]; rtc_b[1] = old + 8'd1;
    repeat (4) @(negedge clk);
    simple_read(8'h0A, d); chk("R10 frozen while updating", d, old);
    rtc_upd = 1'b0; repeat (4) @(negedge clk);
    simple_read(8'h0A, d); chk("R10 after update ends", d, old + 8'd1);

    // constrained random reads
    for (int n = 0; n < 40; n++) begin
      logic [6:0] ra1, ra2; logic [7:0] rc;
      randomize_inputs();
      ra1 = ($urandom % 4 != 0) ? OWN : (OWN ^ 7'(1 + $urandom % 127));
      ra2 = ($urandom % 5 != 0) ? OWN : (OWN ^ 7'(1 + $urandom % 127));
      rc  = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
      rd_txn(ra1, 1'($urandom), rc, ra2, 1'($urandom), 1'b1, 1'b0, a1, a2, a3, d, x, q);
      chk("R2 random first ack", {7'b0, a1}, {7'b0, ra1 == OWN});
      if (a1) begin
        chk("R4 random command ack", {7'b0, a2}, 8'h01);
        chk("R5 random second ack", {7'b0, a3}, {7'b0, ra2 == OWN});
        if (a3) chk("R6 random data", d, exp_byte(rc));
      end
    end

    chk("R11 enable moved with SCL high", 8'(viol), 8'h00);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule